// File: doc/BRIEF.md
# Single-Bank Command Sequencer

This block steps one memory bank through its command life cycle. From rest it opens the bank, issues one column access (a read or a write), closes the bank again, and returns to rest. It can also run a short refresh detour that leaves from rest and comes straight back. A fault input pulls the machine into a trap state from any state in which the bank is open or closing. The trap state always returns to rest on the next cycle.

The surrounding controller raises one-cycle request levels and watches the encoded state, a busy flag and a completion pulse. The sequencer keeps the bank open for a minimum number of cycles before the column access. Its structure rules out two illegal moves: a column access straight from rest, and a write straight after a read. Requests are sampled only while the machine is at rest. Requests seen in any other state are dropped, not stored.

Top module: `bank_cmd_seq`

## Requirements
- R1: While `rst_i` is high and on the first cycle after it falls, `state_o` is 000, and `busy_o` and `done_o` are 0.
- R2: The state codes are rest 000, open 001, read 010, write 011, close 100, refresh 101 and trap 111. An access runs rest, then open, then read or write, then close, then rest. Read, write and close each last exactly one cycle.
- R3: Without a fault, the open state (001) is held for exactly `ACT_HOLD` consecutive cycles (3 by default) before read or write.
- R4: At rest, refresh has priority over read, and read has priority over write. Refresh lasts one cycle and then returns to rest. The access type chosen at rest decides whether the open state leads to read or to write.
- R5: `fault_i` high in open, read, write or close sends the machine to trap (111) on the next cycle. `fault_i` has no effect at rest or in refresh.
- R6: Trap is left after exactly one cycle, always to rest.
- R7: Rest never moves directly to read or write, and read never moves directly to write.
- R8: `done_o` is a one-cycle pulse, high only in the first rest cycle after close. It is not raised after refresh or trap.
- R9: `busy_o` is high exactly when `state_o` is not 000.
- R10: Requests presented outside rest are not stored. Once the machine is back at rest with no request present, it stays at rest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rd_req_i | input | 1 | Read access request, sampled at rest |
| wr_req_i | input | 1 | Write access request, sampled at rest |
| rfsh_req_i | input | 1 | Refresh request, sampled at rest |
| fault_i | input | 1 | Fault indication |
| state_o | output | 3 | Registered state code |
| busy_o | output | 1 | Registered, high when not at rest |
| done_o | output | 1 | Registered pulse on return to rest from close |

## Verification
The bench builds the block with the default `ACT_HOLD` of 3. This keeps every open phase short, so a few thousand cycles drive each state-to-state move many times, including faults that land on each cycle of the open window and on close. Directed steps pin down the exact cycle of every boundary of the hold window, each priority case and each ignored input. A pseudo-random sweep then compares state, busy and done against a cycle model on every cycle.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;
  localparam int STATE_W = 3;

  // Codes are visible at the port and decoded by the neighbour.
  typedef enum logic [STATE_W-1:0] {
    ST_REST  = 3'b000,
    ST_OPEN  = 3'b001,
    ST_RD    = 3'b010,
    ST_WR    = 3'b011,
    ST_CLOSE = 3'b100,
    ST_RFSH  = 3'b101,
    ST_TRAP  = 3'b111
  } bank_state_e;
endpackage

// File: rtl/act_hold_timer.sv
module act_hold_timer #(
  parameter int HOLD = 3
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic open_i,
  output logic hold_met_o
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt_q;

  assign hold_met_o = open_i && (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i || !open_i) begin
      cnt_q <= '0;
    end else if (!hold_met_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/seq_next_state.sv
module seq_next_state
  import bank_seq_pkg::*;
(
  input  bank_state_e cur_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic        rfsh_i,
  input  logic        fault_i,
  input  logic        hold_met_i,
  input  logic        op_wr_i,
  output bank_state_e nxt_o,
  output logic        take_wr_o
);
  always_comb begin
    nxt_o     = cur_i;
    take_wr_o = op_wr_i;
    unique case (cur_i)
      ST_REST: begin
        if (rfsh_i) begin
          nxt_o = ST_RFSH;
        end else if (rd_i) begin
          nxt_o     = ST_OPEN;
          take_wr_o = 1'b0;
        end else if (wr_i) begin
          nxt_o     = ST_OPEN;
          take_wr_o = 1'b1;
        end else begin
          nxt_o = ST_REST;
        end
      end
      ST_OPEN: begin
        if (fault_i)         nxt_o = ST_TRAP;
        else if (hold_met_i) nxt_o = op_wr_i ? ST_WR : ST_RD;
        else                 nxt_o = ST_OPEN;
      end
      ST_RD, ST_WR: nxt_o = fault_i ? ST_TRAP : ST_CLOSE;
      ST_CLOSE:     nxt_o = fault_i ? ST_TRAP : ST_REST;
      ST_RFSH:      nxt_o = ST_REST;
      ST_TRAP:      nxt_o = ST_REST;
      default:      nxt_o = ST_TRAP;
    endcase
  end
endmodule

// File: rtl/bank_cmd_seq.sv
module bank_cmd_seq
  import bank_seq_pkg::*;
#(
  parameter int ACT_HOLD = 3
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               rd_req_i,
  input  logic               wr_req_i,
  input  logic               rfsh_req_i,
  input  logic               fault_i,
  output logic [STATE_W-1:0] state_o,
  output logic               busy_o,
  output logic               done_o
);
  bank_state_e state_q, state_d;
  logic        op_wr_q, op_wr_d;
  logic        hold_met;

  act_hold_timer #(.HOLD(ACT_HOLD)) u_hold (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .open_i    (state_q == ST_OPEN),
    .hold_met_o(hold_met)
  );

  seq_next_state u_nxt (
    .cur_i     (state_q),
    .rd_i      (rd_req_i),
    .wr_i      (wr_req_i),
    .rfsh_i    (rfsh_req_i),
    .fault_i   (fault_i),
    .hold_met_i(hold_met),
    .op_wr_i   (op_wr_q),
    .nxt_o     (state_d),
    .take_wr_o (op_wr_d)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_REST;
      op_wr_q <= 1'b0;
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      op_wr_q <= op_wr_d;
      busy_o  <= (state_d != ST_REST);
      done_o  <= (state_q == ST_CLOSE) && (state_d == ST_REST);
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/bank_cmd_seq_chk.sv
module bank_cmd_seq_chk #(
  parameter int ACT_HOLD = 3
) (
  input logic       clk_i,
  input logic       rst_i,
  input logic       fault_i,
  input logic [2:0] state_o,
  input logic       busy_o,
  input logic       done_o
);
  localparam int RW = $clog2(ACT_HOLD + 1);
  localparam logic [RW-1:0] RMAX = RW'(ACT_HOLD);

  logic [RW-1:0] open_run_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || state_o != 3'b001) open_run_q <= '0;
    else if (open_run_q != RMAX)    open_run_q <= open_run_q + 1'b1;
  end

  assert_rest_no_access_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == 3'b000) |=> (state_o != 3'b010 && state_o != 3'b011));

  assert_read_no_write_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == 3'b010) |=> (state_o != 3'b011));

  assert_trap_exit_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == 3'b111) |=> (state_o == 3'b000));

  assert_fault_entry_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (fault_i && (state_o == 3'b001 || state_o == 3'b010 ||
                 state_o == 3'b011 || state_o == 3'b100)) |=> (state_o == 3'b111));

  assert_busy_flag_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    busy_o == (state_o != 3'b000));

  assert_done_origin_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> (state_o == 3'b000 && $past(state_o) == 3'b100));

  assert_open_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_o == 3'b010 || state_o == 3'b011) |-> (open_run_q == RMAX));
endmodule

bind bank_cmd_seq bank_cmd_seq_chk #(.ACT_HOLD(ACT_HOLD)) u_chk (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .fault_i(fault_i),
  .state_o(state_o),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/tb_bank_cmd_seq.sv
`timescale 1ns/1ps
module tb_bank_cmd_seq;
  localparam int HOLD = 3;
  localparam logic [2:0] S_REST = 3'b000, S_OPEN = 3'b001, S_RD = 3'b010,
                         S_WR = 3'b011, S_CLOSE = 3'b100, S_RFSH = 3'b101,
                         S_TRAP = 3'b111;

  logic clk = 1'b0;
  logic rst, rd, wr, rf, er;
  logic [2:0] state;
  logic busy, done;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  bank_cmd_seq #(.ACT_HOLD(HOLD)) dut (
    .clk_i(clk), .rst_i(rst), .rd_req_i(rd), .wr_req_i(wr),
    .rfsh_req_i(rf), .fault_i(er), .state_o(state), .busy_o(busy), .done_o(done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic step(input logic r, input logic w, input logic f, input logic e);
    rd = r; wr = w; rf = f; er = e;
    @(negedge clk);
  endtask

  // cycle model of the requirements
  logic [2:0] m_state = S_REST;
  int         m_cnt = 0;
  logic       m_opwr = 1'b0;
  logic       m_done = 1'b0;

  task automatic model_step(input logic r, input logic w, input logic f, input logic e);
    logic [2:0] n;
    n = m_state;
    m_done = 1'b0;
    case (m_state)
      S_REST:  if (f) n = S_RFSH;
               else if (r) begin n = S_OPEN; m_opwr = 1'b0; end
               else if (w) begin n = S_OPEN; m_opwr = 1'b1; end
      S_OPEN:  if (e) n = S_TRAP;
               else if (m_cnt == HOLD - 1) n = m_opwr ? S_WR : S_RD;
      S_RD, S_WR: n = e ? S_TRAP : S_CLOSE;
      S_CLOSE: begin n = e ? S_TRAP : S_REST; m_done = !e; end
      default: n = S_REST;
    endcase
    m_cnt = (m_state == S_OPEN && n == S_OPEN) ? m_cnt + 1 : 0;
    m_state = n;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    rst = 1'b1; rd = 0; wr = 0; rf = 0; er = 0;
    @(negedge clk);
    check("R1 state in reset", state, S_REST);
    check("R1 busy in reset", busy, 0);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    step(0, 0, 0, 0);
    check("R1 state after reset", state, S_REST);
    check("R1 done after reset", done, 0);

    // read access, write request held during the read
    step(1, 0, 0, 0);
    check("R2 open after read request", state, S_OPEN);
    check("R9 busy in open", busy, 1);
    step(0, 0, 0, 0);
    check("R3 open cycle 2", state, S_OPEN);
    step(0, 0, 0, 0);
    check("R3 open cycle 3", state, S_OPEN);
    step(0, 1, 0, 0);
    check("R3 read after hold", state, S_RD);
    step(0, 1, 0, 0);
    check("R7 read goes to close not write", state, S_CLOSE);
    check("R8 no done in close", done, 0);
    step(0, 0, 0, 0);
    check("R2 rest after close", state, S_REST);
    check("R8 done after close", done, 1);
    check("R9 busy at rest", busy, 0);
    step(0, 0, 0, 0);
    check("R8 done single cycle", done, 0);

    // write access with requests during the open window
    step(0, 1, 0, 0);
    check("R2 open after write request", state, S_OPEN);
    step(1, 0, 1, 0);
    step(1, 0, 1, 0);
    check("R10 requests ignored in open", state, S_OPEN);
    step(1, 0, 1, 0);
    check("R4 write chosen at rest", state, S_WR);
    step(0, 0, 0, 0);
    check("R2 close after write", state, S_CLOSE);
    step(0, 0, 0, 0);
    check("R2 rest after write close", state, S_REST);
    step(0, 0, 0, 0);
    check("R10 no stored request", state, S_REST);

    // priority and refresh
    step(1, 1, 1, 0);
    check("R4 refresh wins", state, S_RFSH);
    check("R8 no done entering refresh", done, 0);
    step(1, 1, 0, 1);
    check("R5 fault ignored in refresh", state, S_REST);
    check("R8 no done after refresh", done, 0);
    step(1, 1, 0, 0);
    check("R4 open on both requests", state, S_OPEN);
    step(0, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
    check("R4 read wins over write", state, S_RD);
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    check("R2 back at rest", state, S_REST);

    // faults
    step(0, 0, 0, 1);
    check("R5 fault ignored at rest", state, S_REST);
    check("R9 idle after ignored fault", busy, 0);
    step(1, 0, 0, 0);
    step(0, 0, 0, 1);
    check("R5 fault in open", state, S_TRAP);
    check("R9 busy in trap", busy, 1);
    step(1, 0, 0, 1);
    check("R6 trap to rest", state, S_REST);
    check("R8 no done after trap", done, 0);

    // pseudo-random sweep against the model
    m_state = S_REST; m_cnt = 0;
    for (int i = 0; i < 4000; i++) begin
      logic r, w, f, e;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = lfsr[0]; w = lfsr[1]; f = lfsr[2] & lfsr[7]; e = (lfsr[6:4] == 3'd0);
      model_step(r, w, f, e);
      step(r, w, f, e);
      check("R2 R3 R5 R6 sweep state", state, m_state);
      check("R9 sweep busy", busy, int'(m_state != S_REST));
      check("R8 sweep done", done, m_done);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule